// File: doc/BRIEF.md
# Four-Phase Sampling Time-to-Digital Converter Channel

This block timestamps the rising edges of a digital hit signal. It uses no delay line. One clock is available on four phases spaced a quarter period apart, and the hit is registered on each of them. The four samples are then gathered into the phase-0 domain and put side by side with the last sample of the previous period. The first low-to-high boundary in that window sets a two-bit fine code. The fine code is appended to a wrapping coarse counter that runs on phase 0. With a 360 MHz clock one fine step is about 0.69 ns, which is good enough for drift-chamber timing.

Each report is a single-cycle strobe with a timestamp. The timestamp holds its value until the next report. At most one edge per clock period is reported. An input that stays high produces no further reports until a low sample has been taken. The phase count and the coarse width are parameters; the defaults are four phases and fourteen coarse bits.

Top module: `tdc_multiphase`

## Requirements
- R1: While `rst_n` is low, and after its release until the first report, `tdc_valid` is 0 and `tdc_stamp` is 0.
- R2: The fine field `tdc_stamp[1:0]` is the index p (0 to 3) of the first high sample within the sampling window. Phase p samples at p quarter periods after the phase-0 edge that opens the window, and that same sample was low at the previous sampling instant.
- R3: The coarse field `tdc_stamp[15:2]` is the number of phase-0 rising edges from reset release up to and including the edge that opens the window, modulo 2^14.
- R4: `tdc_valid` goes high immediately after the third phase-0 rising edge that follows the window-opening edge.
- R5: If a window contains more than one low-to-high boundary, exactly one report is made, and it carries the earliest boundary.
- R6: A hit held high for many periods gives one report only.
- R7: A pulse that is high at no sampling instant is not reported.
- R8: `tdc_valid` is high for one cycle per report, and `tdc_stamp` keeps its value on every cycle without a report.
- R9: A rise after the phase-3 instant and before the next phase-0 instant is reported with fine code 0 in the next window, so its coarse value is one higher.
- R10: Rising edges in two consecutive windows are reported on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ph_clk | input | NPH (4) | Phase clocks; bit g lags bit 0 by g/NPH of a period |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | 1 | Hit signal to be timed |
| tdc_valid | output | 1 | One-cycle report strobe, phase-0 domain |
| tdc_stamp | output | CW+log2(NPH) (16) | Coarse count in the upper bits, fine phase code in the low bits |

## Verification
The bench drives the hit at offsets of known nanoseconds after a phase-0 edge that it tracks with its own edge counter. From the offset it computes which phase first sees the high level, whether the hit spills into the next window, and the resulting stamp. The report is due just after the third phase-0 edge after the window opens, so the bench waits for that edge count and samples 2 ns later. It checks one edge further on that the strobe has dropped. A strobe counter that samples every cycle confirms, after each case has settled, that the exact number of reports occurred, which covers the held, doubled and missed pulses.

// File: rtl/tdc_mp_pkg.sv
package tdc_mp_pkg;
   localparam int unsigned PHASES_DEFAULT  = 4;
   localparam int unsigned COARSE_W_DEFAULT = 14;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tdc_phase_capture.sv
module tdc_phase_capture #(
   parameter int unsigned NPH = 4
) (
   input  logic [NPH-1:0] ph_clk,
   input  logic           rst_n,
   input  logic           hit,
   output logic [NPH-1:0] raw
);
   for (genvar g = 0; g < NPH; g++) begin : g_ph
      logic smp_q;
      always_ff @(posedge ph_clk[g] or negedge rst_n) begin
         if (!rst_n) smp_q <= 1'b0;
         else        smp_q <= hit;
      end
      assign raw[g] = smp_q;
   end
endmodule

// File: rtl/tdc_coarse_count.sv
module tdc_coarse_count #(
   parameter int unsigned CW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end
endmodule

// File: rtl/tdc_domain_align.sv
module tdc_domain_align #(
   parameter int unsigned NPH = 4,
   parameter int unsigned CW  = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] raw,
   input  logic [CW-1:0]  count,
   output logic [NPH-1:0] aligned,
   output logic [CW-1:0]  tag
);
   // Every phase sample from the period just ended is taken on the next
   // phase-0 edge; the counter value of that period travels with it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned <= '0;
         tag     <= '0;
      end else begin
         aligned <= raw;
         tag     <= count;
      end
   end
endmodule

// File: rtl/tdc_edge_encoder.sv
module tdc_edge_encoder #(
   parameter int unsigned NPH = 4,
   parameter int unsigned CW  = 14,
   localparam int unsigned FW = $clog2(NPH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] aligned,
   input  logic [CW-1:0]  tag_in,
   output logic           found,
   output logic [FW-1:0]  fine,
   output logic [CW-1:0]  tag_out
);
   logic           prev_q;
   logic [NPH:0]   win;
   logic           rise_c;
   logic [FW-1:0]  fine_c;

   assign win = {aligned, prev_q};

   // Scan from the latest phase down so the earliest boundary wins.
   always_comb begin
      rise_c = 1'b0;
      fine_c = '0;
      for (int i = NPH - 1; i >= 0; i--) begin
         if (win[i+1] && !win[i]) begin
            rise_c = 1'b1;
            fine_c = FW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         found   <= 1'b0;
         fine    <= '0;
         tag_out <= '0;
      end else begin
         prev_q <= aligned[NPH-1];
         found  <= rise_c;
         if (rise_c) begin
            fine    <= fine_c;
            tag_out <= tag_in;
         end
      end
   end
endmodule

// File: rtl/tdc_multiphase.sv
module tdc_multiphase #(
   parameter int unsigned NPH = tdc_mp_pkg::PHASES_DEFAULT,
   parameter int unsigned CW  = tdc_mp_pkg::COARSE_W_DEFAULT,
   localparam int unsigned FW = $clog2(NPH),
   localparam int unsigned SW = CW + FW
) (
   input  logic [NPH-1:0] ph_clk,
   input  logic           rst_n,
   input  logic           hit,
   output logic           tdc_valid,
   output logic [SW-1:0]  tdc_stamp
);
   if (!tdc_mp_pkg::is_pow2(NPH)) begin : g_bad_nph
      $error("tdc_multiphase: NPH must be a power of two, at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("tdc_multiphase: CW must be at least 2");
   end

   logic           clk0;
   logic [NPH-1:0] raw_w;
   logic [CW-1:0]  count_w;
   logic [NPH-1:0] aligned_w;
   logic [CW-1:0]  tag_w;
   logic           found_w;
   logic [FW-1:0]  fine_w;
   logic [CW-1:0]  tag2_w;

   assign clk0 = ph_clk[0];

   tdc_phase_capture #(.NPH(NPH)) u_cap (
      .ph_clk (ph_clk),
      .rst_n  (rst_n),
      .hit    (hit),
      .raw    (raw_w)
   );

   tdc_coarse_count #(.CW(CW)) u_cnt (
      .clk   (clk0),
      .rst_n (rst_n),
      .count (count_w)
   );

   tdc_domain_align #(.NPH(NPH), .CW(CW)) u_align (
      .clk     (clk0),
      .rst_n   (rst_n),
      .raw     (raw_w),
      .count   (count_w),
      .aligned (aligned_w),
      .tag     (tag_w)
   );

   tdc_edge_encoder #(.NPH(NPH), .CW(CW)) u_enc (
      .clk     (clk0),
      .rst_n   (rst_n),
      .aligned (aligned_w),
      .tag_in  (tag_w),
      .found   (found_w),
      .fine    (fine_w),
      .tag_out (tag2_w)
   );

   always_ff @(posedge clk0 or negedge rst_n) begin
      if (!rst_n) begin
         tdc_valid <= 1'b0;
         tdc_stamp <= '0;
      end else begin
         tdc_valid <= found_w;
         if (found_w) tdc_stamp <= {tag2_w, fine_w};
      end
   end
endmodule

// File: rtl/tdc_multiphase_chk.sv
module tdc_multiphase_chk #(
   parameter int unsigned NPH = 4,
   parameter int unsigned CW  = 14,
   localparam int unsigned FW = $clog2(NPH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPH-1:0]   aligned,
   input logic [CW-1:0]    count,
   input logic             valid,
   input logic [CW+FW-1:0] stamp
);
   logic [NPH-1:0] a1, a2, a3;
   logic           prev_c;
   logic [NPH:0]   win_rep;
   logic           edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a1 <= '0; a2 <= '0; a3 <= '0; prev_c <= 1'b0;
      end else begin
         a1 <= aligned; a2 <= a1; a3 <= a2; prev_c <= aligned[NPH-1];
      end
   end

   assign win_rep   = {a2, a3[NPH-1]};
   assign edge_seen = |(aligned & ~{aligned[NPH-2:0], prev_c});

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!valid && stamp == '0);
      end
   end

   // R2 and R6: the reported phase was preceded by a low sample
   assert_fine_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (((win_rep >> stamp[FW-1:0]) & 2'b11) == 2'b10));

   assert_coarse_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (stamp[CW+FW-1:FW] == $past(count, 3)));

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |-> ##2 valid);

   assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_seen |-> ##2 !valid);

   assert_stamp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(stamp));
endmodule

bind tdc_multiphase tdc_multiphase_chk #(.NPH(NPH), .CW(CW)) u_chk (
   .clk     (ph_clk[0]),
   .rst_n   (rst_n),
   .aligned (aligned_w),
   .count   (count_w),
   .valid   (tdc_valid),
   .stamp   (tdc_stamp)
);

// File: tb/sim_tdc_multiphase.sv
`timescale 1ns/1ps
module sim_tdc_multiphase;
   logic [3:0]  ph_clk;
   logic        rst_n;
   logic        hit;
   logic        tdc_valid;
   logic [15:0] tdc_stamp;

   int checks = 0;
   int errors = 0;
   int ecnt   = 0;
   int nval   = 0;
   bit done   = 0;

   tdc_multiphase u0 (
      .ph_clk    (ph_clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .tdc_valid (tdc_valid),
      .tdc_stamp (tdc_stamp)
   );

   // 50 MHz, four phases 5 ns apart
   initial begin
      ph_clk = 4'b0000;
      forever begin
         for (int i = 0; i < 4; i++) begin
            #5;
            ph_clk[i] = 1'b1;
            ph_clk[(i + 2) % 4] = 1'b0;
         end
      end
   end

   always @(posedge ph_clk[0] or negedge rst_n) begin
      if (!rst_n) ecnt <= 0;
      else        ecnt <= ecnt + 1;
   end

   always @(posedge ph_clk[0]) begin
      #2;
      if (tdc_valid === 1'b1) nval++;
   end

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic wait_edge(input int target);
      forever begin
         @(posedge ph_clk[0]);
         #1;
         if (ecnt == target) break;
      end
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // A single rise at offset d ns after a phase-0 edge, held for hold_cyc periods
   task automatic hit_case(input string req, input int d, input int hold_cyc);
      int n, v0, p, c, f;
      logic [15:0] exp;
      @(posedge ph_clk[0]);
      #1;
      n  = ecnt;
      v0 = nval;
      #(d - 1);
      hit = 1'b1;
      p   = (d + 4) / 5;
      c   = p / 4;
      f   = p % 4;
      exp = {14'(n + c), 2'(f)};
      wait_edge(n + 3 + c);
      check(tdc_valid === 1'b1, $sformatf("%s/R4 valid d=%0d actual=%b expected=1", req, d, tdc_valid));
      check(tdc_stamp === exp, $sformatf("%s/R2/R3 stamp d=%0d actual=%h expected=%h", req, d, tdc_stamp, exp));
      wait_edge(n + 4 + c);
      check(tdc_valid === 1'b0, $sformatf("%s/R8 strobe drop d=%0d actual=%b expected=0", req, d, tdc_valid));
      check(tdc_stamp === exp, $sformatf("%s/R8 stamp hold d=%0d actual=%h expected=%h", req, d, tdc_stamp, exp));
      repeat (hold_cyc) @(posedge ph_clk[0]);
      #3;
      hit = 1'b0;
      repeat (5) @(posedge ph_clk[0]);
      #4;
      check(nval - v0 == 1, $sformatf("%s report count d=%0d actual=%0d expected=1", req, d, nval - v0));
   endtask

   initial begin
      int n, v0;
      logic [15:0] held;
      rst_n = 1'b0;
      hit   = 1'b0;
      #30;
      check(tdc_valid === 1'b0 && tdc_stamp === 16'h0,
            $sformatf("R1 in reset actual=%b/%h expected=0/0000", tdc_valid, tdc_stamp));
      #22;
      rst_n = 1'b1;
      repeat (4) @(posedge ph_clk[0]);
      #2;
      check(tdc_valid === 1'b0 && tdc_stamp === 16'h0,
            $sformatf("R1 after release actual=%b/%h expected=0/0000", tdc_valid, tdc_stamp));

      // R2/R3/R9 sweep of rise offsets over a whole period
      for (int d = 1; d < 20; d++) begin
         if (d % 5 != 0) hit_case(d > 15 ? "R9" : "R2", d, 1);
      end

      // R6: held high for 20 periods
      hit_case("R6", 7, 20);

      // R5: two boundaries in one window, earliest reported
      @(posedge ph_clk[0]);
      #1;
      n = ecnt; v0 = nval;
      #1;  hit = 1'b1;
      #5;  hit = 1'b0;
      #5;  hit = 1'b1;
      #10; hit = 1'b0;
      wait_edge(n + 3);
      check(tdc_valid === 1'b1 && tdc_stamp === {14'(n), 2'd1},
            $sformatf("R5 earliest actual=%b/%h expected=1/%h", tdc_valid, tdc_stamp, {14'(n), 2'd1}));
      repeat (5) @(posedge ph_clk[0]);
      #4;
      check(nval - v0 == 1, $sformatf("R5 report count actual=%0d expected=1", nval - v0));

      // R7: pulse between sampling instants
      held = tdc_stamp;
      @(posedge ph_clk[0]);
      #1;
      v0 = nval;
      #5; hit = 1'b1;
      #3; hit = 1'b0;
      repeat (6) @(posedge ph_clk[0]);
      #4;
      check(nval - v0 == 0, $sformatf("R7 missed pulse reports actual=%0d expected=0", nval - v0));
      check(tdc_stamp === held, $sformatf("R7/R8 stamp unchanged actual=%h expected=%h", tdc_stamp, held));

      // R10: rises in consecutive windows
      @(posedge ph_clk[0]);
      #1;
      n = ecnt; v0 = nval;
      #1;  hit = 1'b1;
      #10; hit = 1'b0;
      #15; hit = 1'b1;
      wait_edge(n + 3);
      check(tdc_valid === 1'b1 && tdc_stamp === {14'(n), 2'd1},
            $sformatf("R10 first actual=%b/%h expected=1/%h", tdc_valid, tdc_stamp, {14'(n), 2'd1}));
      wait_edge(n + 4);
      check(tdc_valid === 1'b1 && tdc_stamp === {14'(n + 1), 2'd2},
            $sformatf("R10 second actual=%b/%h expected=1/%h", tdc_valid, tdc_stamp, {14'(n + 1), 2'd2}));
      #3; hit = 1'b0;
      repeat (5) @(posedge ph_clk[0]);
      #4;
      check(nval - v0 == 2, $sformatf("R10 report count actual=%0d expected=2", nval - v0));

      // R3 wrap: window opened by edge 16383, rise spills into edge 16384
      forever begin
         @(posedge ph_clk[0]);
         #1;
         if (ecnt == 16382) break;
      end
      hit_case("R3 wrap", 17, 1);

      finish_run();
   end

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog R4 actual=timeout expected=completion");
      finish_run();
   end
endmodule